// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in, and returns the sum and the carry-out. It has no clock and no state, so the result follows the inputs within the same cycle.

Each bit position has a cell that forms the sum bit and a pair of signals. One signal says the position generates a carry. The other says it passes an incoming carry through. Groups of four cells feed one four-input lookahead unit. That unit returns the four carries into its group, plus a group-level generate/propagate pair.

The same unit design is reused at every level of a tree of fan-out four. Each level of units consumes the pairs produced by the level below it. The root unit receives the external carry-in. Its group pair produces the external carry-out.

The operand width is a parameter and must be a power of four: 4 needs one lookahead level, 16 needs two, and 64 needs three. The number of levels is derived from the width, and no other setting is needed.

Top module: `cla_adder`

## Requirements
- R1: For every input combination, `sum_out` equals (`a_in` + `b_in` + `c_in`) mod 2^WIDTH, and `c_out` equals bit WIDTH of that full sum.
- R2: WIDTH must be a power of four and at least 4. Any other value stops elaboration. The valid widths 4, 16 and 64 each produce a correct adder, with one, two and three lookahead levels.
- R3: Each bit cell produces propagate = a XOR b, generate = a AND b, and sum = propagate XOR carry-in. Propagate and generate are never both 1 at a cell.
- R4: Within a group of four, the carry into position i+1 is 1 exactly when position i generates, or when position i propagates and the carry into position i is 1. The carry into position 0 of the group is the group's carry-in.
- R5: A group's propagate output is 1 only when all four of its inputs propagate. Its generate output is 1 when a carry leaves the group with a carry-in of 0. The two are never both 1. Carries cross group boundaries correctly.
- R6: When `b_in` is the bitwise inverse of `a_in`, every position propagates. The result is then all ones with `c_out` = 0 if `c_in` = 0, and all zeros with `c_out` = 1 if `c_in` = 1.
- R7: All-ones plus all-ones gives all ones except bit 0 (which equals `c_in`), with `c_out` = 1. All-zeros plus all-zeros gives `sum_out` = `c_in` and `c_out` = 0.
- R8: `c_out` is the root group's generate, or the root group's propagate ANDed with `c_in`. As a result, all ones plus zero gives `c_out` = `c_in`.
- R9: The outputs depend only on the present inputs. The same input vector gives the same result whatever vectors came before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum modulo 2^WIDTH |
| c_out | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a carry that rides the propagate path through every level of the tree. In that case `c_in` alone decides all upper carries. Random operands almost never make every position propagate, because that happens with probability 2^-WIDTH.

The stimulus therefore drives complementary operand pairs with both carry-in values. It also drives runs of ones that end exactly at group boundaries, so that a generate at one group must travel through the next level's propagate path. The 4-bit build is covered exhaustively, and the wider builds compare each vector against a plain arithmetic sum.

// File: rtl/cla_pkg.sv
package cla_pkg;

   // 1 when w is 4, 16, 64, ...
   function automatic bit is_pow4(input int w);
      int v;
      v = w;
      if (v < 4) return 1'b0;
      while (v > 1) begin
         if ((v % 4) != 0) return 1'b0;
         v = v / 4;
      end
      return 1'b1;
   endfunction

   // number of lookahead levels above the bit cells
   function automatic int levels_of(input int w);
      int v;
      int n;
      v = w;
      n = 0;
      while (v > 1) begin
         v = v / 4;
         n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic p,
   output logic g
);
   assign p = a ^ b;
   assign g = a & b;
   assign s = p ^ ci;
endmodule

// File: rtl/cla_slice4.sv
module cla_slice4 #(
   parameter int LANES = 4
) (
   input  logic [LANES-1:0] a,
   input  logic [LANES-1:0] b,
   input  logic [LANES-1:0] ci,
   output logic [LANES-1:0] s,
   output logic [LANES-1:0] p,
   output logic [LANES-1:0] g
);
   if (LANES != 4) begin : g_bad_lanes
      $error("cla_slice4: LANES must be 4");
   end

   for (genvar k = 0; k < LANES; k++) begin : g_cell
      cla_bit_cell u_cell (
         .a (a[k]),
         .b (b[k]),
         .ci(ci[k]),
         .s (s[k]),
         .p (p[k]),
         .g (g[k])
      );
   end

   always_comb begin
      for (int k = 0; k < LANES; k++) begin
         AST_CELL_PG_EXCL: assert (!(p[k] && g[k])) else $error("cell %0d both P and G", k); // R3
      end
   end
endmodule

// File: rtl/cla_unit4.sv
module cla_unit4 #(
   parameter int FANIN = 4
) (
   input  logic [FANIN-1:0] p,
   input  logic [FANIN-1:0] g,
   input  logic             cin,
   output logic [FANIN-1:0] carry,
   output logic             grp_p,
   output logic             grp_g
);
   if (FANIN != 4) begin : g_bad_fanin
      $error("cla_unit4: FANIN must be 4");
   end

   // Carry leaving position 'upto', as a flat sum of products over inputs only.
   function automatic logic carry_term(input logic [FANIN-1:0] pp,
                                       input logic [FANIN-1:0] gg,
                                       input logic c0,
                                       input int upto);
      logic acc;
      logic prod;
      prod = c0;
      for (int m = 0; m <= upto; m++) prod = prod & pp[m];
      acc = prod;
      for (int k = 0; k <= upto; k++) begin
         prod = gg[k];
         for (int m = k + 1; m <= upto; m++) prod = prod & pp[m];
         acc = acc | prod;
      end
      return acc;
   endfunction

   always_comb begin
      carry[0] = cin;
      for (int i = 0; i < FANIN - 1; i++) carry[i+1] = carry_term(p, g, cin, i);
      grp_g = carry_term(p, g, 1'b0, FANIN - 1);
      grp_p = &p;

      for (int i = 0; i < FANIN - 1; i++) begin
         AST_GEN_SETS_CARRY: assert (!g[i] || carry[i+1]) else $error("generate lost at %0d", i); // R4
         AST_KILL_CLEARS_CARRY: assert (g[i] || p[i] || !carry[i+1]) else $error("carry from killed position %0d", i); // R4
         AST_PROP_PASSES_CARRY: assert (!(p[i] && !g[i]) || (carry[i+1] == carry[i])) else $error("propagate broken at %0d", i); // R4
      end
      AST_GRP_PG_EXCL: assert (!(grp_p && grp_g)) else $error("group P and G both set"); // R5
   end
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             c_in,
   output logic [WIDTH-1:0] sum_out,
   output logic             c_out
);
   import cla_pkg::*;

   localparam int FAN    = 4;
   localparam int LEVELS = levels_of(WIDTH);
   localparam int SLICES = WIDTH / FAN;

   if (!is_pow4(WIDTH)) begin : g_bad_width
      $error("cla_adder: WIDTH %0d is not a power of four (R2)", WIDTH);
   end

   // One scope per level: level 0 holds bit signals, level L the root pair.
   for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
      localparam int N = WIDTH >> (2 * l);
      logic [N-1:0] p;
      logic [N-1:0] g;
      logic [N-1:0] c;
   end

   for (genvar s = 0; s < SLICES; s++) begin : g_slice
      cla_slice4 #(.LANES(FAN)) u_slice (
         .a (a_in[FAN*s +: FAN]),
         .b (b_in[FAN*s +: FAN]),
         .ci(g_lvl[0].c[FAN*s +: FAN]),
         .s (sum_out[FAN*s +: FAN]),
         .p (g_lvl[0].p[FAN*s +: FAN]),
         .g (g_lvl[0].g[FAN*s +: FAN])
      );
   end

   for (genvar l = 1; l <= LEVELS; l++) begin : g_tree
      localparam int CNT = WIDTH >> (2 * l);
      for (genvar j = 0; j < CNT; j++) begin : g_unit
         cla_unit4 #(.FANIN(FAN)) u_unit (
            .p    (g_lvl[l-1].p[FAN*j +: FAN]),
            .g    (g_lvl[l-1].g[FAN*j +: FAN]),
            .cin  (g_lvl[l].c[j]),
            .carry(g_lvl[l-1].c[FAN*j +: FAN]),
            .grp_p(g_lvl[l].p[j]),
            .grp_g(g_lvl[l].g[j])
         );
      end
   end

   assign g_lvl[LEVELS].c[0] = c_in;
   assign c_out = g_lvl[LEVELS].g[0] | (g_lvl[LEVELS].p[0] & c_in);   // R8
endmodule

// File: tb/sim_cla_adder.sv
module sim_cla_adder;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [63:0] a64, b64;
   logic        cin;
   logic [3:0]  s4;
   logic [15:0] s16;
   logic [63:0] s64;
   logic        co4, co16, co64;

   // R2: one build of each legal width
   cla_adder #(.WIDTH(16)) u0 (.a_in(a64[15:0]), .b_in(b64[15:0]), .c_in(cin), .sum_out(s16), .c_out(co16));
   cla_adder #(.WIDTH(4))  u1 (.a_in(a64[3:0]),  .b_in(b64[3:0]),  .c_in(cin), .sum_out(s4),  .c_out(co4));
   cla_adder #(.WIDTH(64)) u2 (.a_in(a64),       .b_in(b64),       .c_in(cin), .sum_out(s64), .c_out(co64));

   typedef struct {
      logic [4:0]  e4;
      logic [16:0] e16;
      logic [64:0] e64;
      string       req;
   } item_t;

   item_t q[$];
   int    n_run = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic c, input string req);
      item_t it;
      @(posedge clk);
      #1;
      a64 = a; b64 = b; cin = c;
      it.e4  = {1'b0, a[3:0]}  + {1'b0, b[3:0]}  + 5'(c);
      it.e16 = {1'b0, a[15:0]} + {1'b0, b[15:0]} + 17'(c);
      it.e64 = {1'b0, a}       + {1'b0, b}       + 65'(c);
      it.req = req;
      q.push_back(it);
   endtask

   // monitor: compare half a cycle after each drive
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         n_run++;
         if ({co16, s16} !== it.e16) begin
            n_fail++;
            $display("FAIL %s w16: got %h exp %h", it.req, {co16, s16}, it.e16);
         end
         n_run++;
         if ({co4, s4} !== it.e4) begin
            n_fail++;
            $display("FAIL R2 %s w4: got %h exp %h", it.req, {co4, s4}, it.e4);
         end
         n_run++;
         if ({co64, s64} !== it.e64) begin
            n_fail++;
            $display("FAIL R2 %s w64: got %h exp %h", it.req, {co64, s64}, it.e64);
         end
      end
   end

   localparam logic [63:0] ONES = '1;

   initial begin
      a64 = '0; b64 = '0; cin = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      drive('0, '0, 1'b0, "R1 reset-state zero");
      // R3: exhaustive 4-bit
      for (int i = 0; i < 512; i++) begin
         drive(64'(i[3:0]) * 64'h1111_1111_1111_1111, 64'(i[7:4]) * 64'h1111_1111_1111_1111, i[8], "R3 exhaustive");
      end
      // R4: ripple runs inside a group
      for (int k = 0; k < 4; k++) begin
         drive((64'd1 << k) - 64'd1, 64'd1, 1'b0, "R4 run");
         drive(64'd1 << k, 64'd1 << k, 1'b1, "R4 gen");
      end
      // R5: runs ending on group boundaries, crossing levels
      for (int k = 4; k <= 64; k += 4) begin
         drive(ONES >> (64 - k), 64'd1, 1'b0, "R5 boundary run");
         drive(ONES >> (64 - k), 64'd0, 1'b1, "R5 boundary via cin");
      end
      // R6: full propagate
      for (int i = 0; i < 8; i++) begin
         logic [63:0] pat;
         pat = {$urandom, $urandom};
         drive(pat, ~pat, 1'b0, "R6 full propagate");
         drive(pat, ~pat, 1'b1, "R6 full propagate");
      end
      // R7: extremes
      drive(ONES, ONES, 1'b0, "R7 ones");
      drive(ONES, ONES, 1'b1, "R7 ones");
      drive('0, '0, 1'b1, "R7 zeros");
      // R8: root propagate path
      drive(ONES, '0, 1'b1, "R8 root P");
      drive(ONES, '0, 1'b0, "R8 root P");
      drive('0, ONES, 1'b1, "R8 root P");
      // R9: history independence
      drive(64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321, 1'b1, "R9 first");
      drive(ONES, ONES, 1'b1, "R9 other");
      drive(64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321, 1'b1, "R9 repeat");
      // R1: random
      for (int i = 0; i < 3000; i++) begin
         drive({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 random");
      end
      while (q.size() > 0) @(posedge clk);
      @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule